// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that moves 32-bit words from a source address to a destination address. The work comes from a chain of descriptors kept in memory. Software writes the address of the first descriptor into the channel and then sets the run bit. The channel reads the first six words of the 32-byte descriptor: an option word, the source, the destination, the length, the row stride and the link to the next descriptor. It then copies the data. When a descriptor is finished the channel follows the link, and it stops when the link is zero.

A copy runs in one of two shapes. In linear mode the length word is a byte count. In strided mode the length word holds a row count and a row width, and a signed offset is added to each address after every row. Each address can step by one word or stay fixed. Software can pause the channel, resume it, abandon the current descriptor or wipe the whole channel. An external hold line can stall transfers, but only for descriptors that ask for pacing. The completion interrupt is raised per descriptor, and only when that descriptor asks for it.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, the control word at offset 0x00 reads 0x0000_0010 (idle). `irq` is low and the memory port is inactive.
- R2: Software writes a descriptor address to offset 0x04 and then writes bit 0 (run) of the control word. The channel then reads descriptor words 0..5 from that address: option, source, destination, length, stride and link.
- R3: In linear mode (option bit 1 clear) the channel moves length/4 words, one read and then one write per word. The source address steps by 4 when option bit 8 is set, and the destination steps by 4 when option bit 4 is set. When a bit is clear, the same address is used for every word.
- R4: In strided mode (option bit 1 set), length[31:16] gives the number of rows and length[15:0] gives the bytes per row. After the last word of each row, the sign-extended stride[15:0] is added to the source and the sign-extended stride[31:16] is added to the destination.
- R5: A non-zero link makes the channel fetch the next descriptor. A zero link clears the run bit and returns the channel to idle.
- R6: When a descriptor with option bit 0 set completes, control bit 2 and `irq` are set. Writing the control word with bit 2 set clears them.
- R7: Writing the control word with bit 0 clear pauses the channel once the current word is done. Control bit 4 then reads 1 and no memory access happens. Writing bit 0 set resumes the copy with no loss.
- R8: Writing the control word with bits 30 and 0 both set ends the current descriptor at a word boundary, with no interrupt for it. The channel then continues with the link.
- R9: Writing the control word with bit 31 set returns the channel to its reset state. All registers read zero and the control word reads 0x10.
- R10: While `dreq_hold` is high, reads stall for a descriptor with option bit 10 set, and writes stall for one with option bit 6 set. Control bit 5 reads 1 while stalled.
- R11: A descriptor address whose low 5 bits are not zero sets control bit 8, clears the run bit and leaves the channel idle.
- R12: Offsets 0x08, 0x0C, 0x10 and 0x1C read the option word, the current source address, the current destination address and the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_re | output | 1 | Memory read strobe, data returned in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| dreq_hold | input | 1 | Pacing hold from a peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
Random linear copies vary the length and both step bits. They show whether the word count and each address stepping rule are applied separately. Random strided copies use positive, zero and negative destination offsets. A stride applied at the wrong point, or one that loses its sign, therefore shows up in the final memory image. Directed chains, pause/resume, abort, wipe, hold and a misaligned start each test one control path. Memory contents are checked against a bench copy model, and the registers are checked against values from the requirements.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int FETCH_LAST = 5;  // option, src, dst, len, stride, link

    // control word bit positions
    localparam int CS_RUN   = 0;
    localparam int CS_IRQ   = 2;
    localparam int CS_PAUSE = 4;
    localparam int CS_HELD  = 5;
    localparam int CS_ERR   = 8;
    localparam int CS_ABORT = 30;
    localparam int CS_WIPE  = 31;

    // option word bit positions
    localparam int OPT_IEN  = 0;
    localparam int OPT_2D   = 1;
    localparam int OPT_DINC = 4;
    localparam int OPT_DPACE = 6;
    localparam int OPT_SINC = 8;
    localparam int OPT_SPACE = 10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_DONE
    } chan_state_e;

    typedef struct packed {
        chan_state_e         st;
        logic                run;
        logic                intr;
        logic                err;
        logic                abt;
        logic [2:0]          fidx;
        logic [WORD_W-1:0]   cb;
        logic [WORD_W-1:0]   opt;
        logic [WORD_W-1:0]   src;
        logic [WORD_W-1:0]   dst;
        logic [WORD_W-1:0]   len;
        logic [WORD_W-1:0]   stride;
        logic [WORD_W-1:0]   link;
        logic [WORD_W-1:0]   data;
        logic [CNT_W-1:0]    wleft;
        logic [CNT_W-1:0]    rows;
    } chan_s;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          inc,
    input  logic          row_end,
    input  logic [SW-1:0] stride,
    output logic [AW-1:0] next
);
    logic [AW-1:0] step;
    logic [AW-1:0] jump;

    always_comb begin
        step = inc ? AW'(4) : '0;
        jump = row_end ? {{(AW-SW){stride[SW-1]}}, stride} : '0;
        next = addr + step + jump;
    end
endmodule

// File: rtl/dma_csr_view.sv
module dma_csr_view #(
    parameter int RAW = 6,
    parameter int DW  = 32
) (
    input  logic [RAW-1:0] addr,
    input  logic [DW-1:0]  cs,
    input  logic [DW-1:0]  cb,
    input  logic [DW-1:0]  opt,
    input  logic [DW-1:0]  src,
    input  logic [DW-1:0]  dst,
    input  logic [DW-1:0]  len,
    input  logic [DW-1:0]  stride,
    input  logic [DW-1:0]  link,
    output logic [DW-1:0]  rdata
);
    always_comb begin
        case (addr)
            RAW'(8'h00): rdata = cs;
            RAW'(8'h04): rdata = cb;
            RAW'(8'h08): rdata = opt;
            RAW'(8'h0C): rdata = src;
            RAW'(8'h10): rdata = dst;
            RAW'(8'h14): rdata = len;
            RAW'(8'h18): rdata = stride;
            RAW'(8'h1C): rdata = link;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int REG_AW   = 6,
    parameter int CB_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              dreq_hold,
    output logic              irq
);
    localparam int ALIGN_W = $clog2(CB_WORDS * 4);

    chan_s q, d;
    logic [WORD_W-1:0] src_nx, dst_nx, cs_word;
    logic row_last, row_end, more_rows;
    logic wr_cs, abort_cmd, wipe_cmd;
    logic cs_active, cs_paused, cs_held;

    assign wr_cs     = reg_we && (reg_addr == '0);
    assign wipe_cmd  = wr_cs && reg_wdata[CS_WIPE];
    assign abort_cmd = wr_cs && reg_wdata[CS_ABORT] && reg_wdata[CS_RUN] && !wipe_cmd;
    assign row_last  = (q.wleft == CNT_W'(1));
    assign more_rows = q.opt[OPT_2D] && (q.rows > CNT_W'(1));
    assign row_end   = row_last && q.opt[OPT_2D];

    dma_addr_step #(.AW(WORD_W), .SW(16)) u_src_step (
        .addr(q.src), .inc(q.opt[OPT_SINC]), .row_end(row_end),
        .stride(q.stride[15:0]), .next(src_nx)
    );
    dma_addr_step #(.AW(WORD_W), .SW(16)) u_dst_step (
        .addr(q.dst), .inc(q.opt[OPT_DINC]), .row_end(row_end),
        .stride(q.stride[31:16]), .next(dst_nx)
    );

    always_comb begin
        d         = q;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = q.data;
        cs_held   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (q.run) begin
                    if (q.cb[ALIGN_W-1:0] != '0) begin
                        d.err = 1'b1;
                        d.run = 1'b0;
                    end else begin
                        d.st   = ST_FETCH;
                        d.fidx = '0;
                    end
                end
            end
            ST_FETCH: begin
                if (q.run) begin
                    mem_re   = 1'b1;
                    mem_addr = q.cb + (WORD_W'(q.fidx) << 2);
                    case (q.fidx)
                        3'd0:    d.opt    = mem_rdata;
                        3'd1:    d.src    = mem_rdata;
                        3'd2:    d.dst    = mem_rdata;
                        3'd3:    d.len    = mem_rdata;
                        3'd4:    d.stride = mem_rdata;
                        default: d.link   = mem_rdata;
                    endcase
                    d.fidx = q.fidx + 3'd1;
                    if (q.fidx == 3'(FETCH_LAST)) begin
                        d.wleft = q.opt[OPT_2D] ? {2'b00, q.len[15:2]} : q.len[CNT_W+1:2];
                        d.rows  = q.opt[OPT_2D] ? q.len[31:16] : CNT_W'(1);
                        d.st    = (d.wleft == '0 || d.rows == '0) ? ST_DONE : ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (abort_cmd) begin
                    d.st  = ST_DONE;
                    d.abt = 1'b1;
                end else if (!q.run) begin
                    d.st = ST_READ;
                end else if (q.opt[OPT_SPACE] && dreq_hold) begin
                    cs_held = 1'b1;
                end else begin
                    mem_re   = 1'b1;
                    mem_addr = q.src;
                    d.data   = mem_rdata;
                    d.st     = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (q.opt[OPT_DPACE] && dreq_hold) begin
                    cs_held = 1'b1;
                    if (abort_cmd) begin
                        d.st  = ST_DONE;
                        d.abt = 1'b1;
                    end
                end else begin
                    mem_we   = 1'b1;
                    mem_addr = q.dst;
                    d.src    = src_nx;
                    d.dst    = dst_nx;
                    d.st     = ST_READ;
                    if (row_last) begin
                        if (more_rows) begin
                            d.rows  = q.rows - CNT_W'(1);
                            d.wleft = {2'b00, q.len[15:2]};
                        end else begin
                            d.st = ST_DONE;
                        end
                    end else begin
                        d.wleft = q.wleft - CNT_W'(1);
                    end
                    if (abort_cmd) begin
                        d.st  = ST_DONE;
                        d.abt = 1'b1;
                    end
                end
            end
            default: begin
                if (q.opt[OPT_IEN] && !q.abt) d.intr = 1'b1;
                d.abt = 1'b0;
                if (q.link == '0) begin
                    d.run = 1'b0;
                    d.st  = ST_IDLE;
                end else begin
                    d.cb = q.link;
                    if (q.link[ALIGN_W-1:0] != '0) begin
                        d.err = 1'b1;
                        d.run = 1'b0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.st   = ST_FETCH;
                        d.fidx = '0;
                    end
                end
            end
        endcase

        if (wipe_cmd) begin
            d = '0;
        end else if (wr_cs) begin
            d.run = reg_wdata[CS_RUN];
            if (reg_wdata[CS_IRQ]) d.intr = 1'b0;
        end else if (reg_we && reg_addr == REG_AW'(8'h04)) begin
            d.cb = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cs_active = q.run;
    assign cs_paused = (q.st == ST_IDLE) ||
                       (!q.run && (q.st == ST_READ || q.st == ST_FETCH));
    assign irq       = q.intr;

    always_comb begin
        cs_word           = '0;
        cs_word[CS_RUN]   = q.run;
        cs_word[CS_IRQ]   = q.intr;
        cs_word[CS_PAUSE] = cs_paused;
        cs_word[CS_HELD]  = cs_held;
        cs_word[CS_ERR]   = q.err;
    end

    dma_csr_view #(.RAW(REG_AW), .DW(WORD_W)) u_view (
        .addr(reg_addr), .cs(cs_word), .cb(q.cb), .opt(q.opt),
        .src(q.src), .dst(q.dst), .len(q.len), .stride(q.stride),
        .link(q.link), .rdata(reg_rdata)
    );
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_re,
    input logic        mem_we,
    input logic        irq,
    input logic        cs_active,
    input logic        cs_paused,
    input logic        cs_held
);
    // R3
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R7
    paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_paused |-> (!mem_re && !mem_we));

    // R9
    wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 6'h00 && reg_wdata[31]) |=> (!cs_active && !irq));

    // R10
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_held |-> (!mem_re && !mem_we));
endmodule

bind dma_chain_channel dma_chain_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_re(mem_re), .mem_we(mem_we), .irq(irq),
    .cs_active(cs_active), .cs_paused(cs_paused), .cs_held(cs_held)
);

// File: tb/tb_dma_chain_channel.sv
`timescale 1ns/1ps
module tb_dma_chain_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_re, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        dreq_hold = 1'b0;
    logic        irq;

    logic [31:0] mem     [0:1023];
    logic [31:0] exp_mem [0:1023];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    dma_chain_channel dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dreq_hold(dreq_hold), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic put_cb(input int base, input logic [31:0] opt, input logic [31:0] s,
                          input logic [31:0] dd, input logic [31:0] len,
                          input logic [31:0] strd, input logic [31:0] link);
        logic [31:0] w [6];
        w = '{opt, s, dd, len, strd, link};
        for (int i = 0; i < 6; i++) begin
            mem[base/4 + i] = w[i];
            exp_mem[base/4 + i] = w[i];
        end
    endtask

    // bench copy model following the requirements R3, R4, R5
    task automatic ref_run(input logic [31:0] cb, output bit want_irq);
        logic [31:0] opt, s, dd, len, st, link;
        int words, rows;
        want_irq = 0;
        forever begin
            opt = exp_mem[cb[11:2]];   s  = exp_mem[cb[11:2] + 1];
            dd  = exp_mem[cb[11:2] + 2]; len = exp_mem[cb[11:2] + 3];
            st  = exp_mem[cb[11:2] + 4]; link = exp_mem[cb[11:2] + 5];
            words = opt[1] ? int'(len[15:2]) : int'(len[17:2]);
            rows  = opt[1] ? int'(len[31:16]) : 1;
            for (int r = 0; r < rows; r++) begin
                for (int k = 0; k < words; k++) begin
                    exp_mem[dd[11:2]] = exp_mem[s[11:2]];
                    if (opt[8]) s  = s + 4;
                    if (opt[4]) dd = dd + 4;
                end
                if (opt[1]) begin
                    s  = s  + {{16{st[15]}}, st[15:0]};
                    dd = dd + {{16{st[31]}}, st[31:16]};
                end
            end
            if (opt[0]) want_irq = 1;
            if (link == 0) break;
            cb = link;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(6'h00, v);
            if (!v[0]) break;
        end
    endtask

    task automatic start(input logic [31:0] cb);
        wr(6'h04, cb);
        wr(6'h00, 32'h1);
    endtask

    task automatic cmp_mem(input string tag);
        int miss = 0;
        int first = -1;
        for (int i = 256; i < 1024; i++)
            if (mem[i] !== exp_mem[i]) begin
                miss++;
                if (first < 0) first = i;
            end
        chk(miss == 0, tag, (first < 0) ? 32'h0 : mem[first],
            (first < 0) ? 32'h0 : exp_mem[first]);
    endtask

    task automatic resync();
        for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v1;
        bit wi;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = $urandom;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h00, v);
        chk(v == 32'h10, "R1 control after reset", v, 32'h10);
        chk(irq == 1'b0 && mem_re == 1'b0 && mem_we == 1'b0, "R1 outputs idle",
            {29'b0, irq, mem_re, mem_we}, 32'h0);

        // R2 R3 R12 R6 directed linear copy with interrupt
        put_cb(32'h000, 32'h111, 32'h400, 32'h800, 32'd16, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000);
        wait_idle();
        cmp_mem("R2 R3 linear copy");
        rd(6'h08, v); chk(v == 32'h111, "R12 option readback", v, 32'h111);
        rd(6'h0C, v); chk(v == 32'h410, "R12 source readback", v, 32'h410);
        rd(6'h10, v); chk(v == 32'h810, "R12 destination readback", v, 32'h810);
        rd(6'h1C, v); chk(v == 32'h0, "R12 link readback", v, 32'h0);
        rd(6'h00, v); chk(v[2] && irq, "R6 interrupt set", {v[2], irq}, 2'b11);
        wr(6'h00, 32'h4);
        rd(6'h00, v); chk(!v[2] && !irq, "R6 interrupt cleared", {v[2], irq}, 2'b00);

        // R3 fixed source: every destination word equals the first source word
        put_cb(32'h000, 32'h010, 32'h440, 32'h880, 32'd32, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000); wait_idle();
        cmp_mem("R3 fixed source fill");
        chk(mem[32'h89C/4] == mem[32'h440/4], "R3 fill last word", mem[32'h89C/4], mem[32'h440/4]);

        // R3 fixed destination: last source word remains
        put_cb(32'h000, 32'h100, 32'h480, 32'h8C0, 32'd20, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000); wait_idle();
        chk(mem[32'h8C0/4] == mem[32'h490/4], "R3 fixed destination", mem[32'h8C0/4], mem[32'h490/4]);

        // R4 directed strided copy with negative destination stride
        put_cb(32'h000, 32'h112, 32'h500, 32'hA00, {16'd3, 16'd8}, {16'hFFF0, 16'h0008}, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000); wait_idle();
        cmp_mem("R4 strided copy negative stride");
        wr(6'h00, 32'h4);

        // R5 chain of three, interrupt only on the last
        put_cb(32'h000, 32'h110, 32'h400, 32'hB00, 32'd8, 32'h0, 32'h020);
        put_cb(32'h020, 32'h110, 32'h420, 32'hB40, 32'd12, 32'h0, 32'h040);
        put_cb(32'h040, 32'h111, 32'h440, 32'hB80, 32'd4, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000); wait_idle();
        cmp_mem("R5 three-descriptor chain");
        rd(6'h00, v);
        chk(v[0] == 1'b0 && v[4] && irq, "R5 chain end idle", v, 32'h14);
        wr(6'h00, 32'h4);

        // random linear and strided copies
        for (int it = 0; it < 30; it++) begin
            logic [31:0] opt, s, dd, len, st;
            if ($urandom_range(1, 0) == 0) begin
                opt = {21'b0, 3'b0, $urandom_range(1, 0) == 1, 3'b0, $urandom_range(1, 0) == 1, 4'b0};
                s   = 32'h400 + 4 * $urandom_range(100, 0);
                dd  = 32'h800 + 4 * $urandom_range(100, 0);
                len = 4 * $urandom_range(16, 1);
                st  = 0;
            end else begin
                int w, r, ss;
                w  = $urandom_range(4, 1); r = $urandom_range(4, 1); ss = $urandom_range(4, 0);
                opt = 32'h112;
                s   = 32'h400 + 4 * $urandom_range(64, 0);
                dd  = 32'h900 + 4 * $urandom_range(64, 0);
                len = {16'(r), 16'(4 * w)};
                st  = ($urandom_range(1, 0) == 1) ? {16'(-8 * w), 16'(4 * ss)}
                                                  : {16'(4 * $urandom_range(4, 0)), 16'(4 * ss)};
            end
            put_cb(32'h000, opt, s, dd, len, st, 32'h0);
            ref_run(32'h000, wi);
            start(32'h000); wait_idle();
            cmp_mem(opt[1] ? "R4 random strided" : "R3 random linear");
            chk(irq == wi, "R6 random irq", {31'b0, irq}, {31'b0, wi});
            wr(6'h00, 32'h4);
        end

        // R7 pause and resume
        put_cb(32'h000, 32'h110, 32'h400, 32'h800, 32'd256, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        start(32'h000);
        repeat (10) @(negedge clk);
        wr(6'h00, 32'h0);
        repeat (3) @(negedge clk);
        rd(6'h10, v1);
        rd(6'h00, v);
        chk(v[4] == 1'b1, "R7 paused bit", v, 32'h10);
        repeat (10) @(negedge clk);
        rd(6'h10, v);
        chk(v == v1, "R7 no progress while paused", v, v1);
        wr(6'h00, 32'h1);
        wait_idle();
        cmp_mem("R7 copy complete after resume");

        // R8 abort current descriptor, continue with link
        put_cb(32'h100, 32'h111, 32'h400, 32'h800, 32'd256, 32'h0, 32'h140);
        put_cb(32'h140, 32'h110, 32'h600, 32'hC00, 32'd16, 32'h0, 32'h0);
        v1 = mem[32'h8FC/4];
        start(32'h100);
        repeat (20) @(negedge clk);
        wr(6'h00, 32'h4000_0001);
        wait_idle();
        chk(mem[32'h8FC/4] == v1, "R8 aborted tail untouched", mem[32'h8FC/4], v1);
        chk(mem[32'hC0C/4] == mem[32'h60C/4], "R8 next descriptor ran", mem[32'hC0C/4], mem[32'h60C/4]);
        chk(irq == 1'b0, "R8 no irq for aborted", {31'b0, irq}, 32'h0);
        resync();

        // R9 wipe during a transfer
        put_cb(32'h000, 32'h111, 32'h400, 32'h800, 32'd256, 32'h0, 32'h0);
        start(32'h000);
        repeat (12) @(negedge clk);
        wr(6'h00, 32'h8000_0000);
        rd(6'h00, v); chk(v == 32'h10, "R9 control after wipe", v, 32'h10);
        rd(6'h08, v); chk(v == 32'h0, "R9 option cleared", v, 32'h0);
        rd(6'h04, v); chk(v == 32'h0, "R9 address cleared", v, 32'h0);
        resync();

        // R10 source pacing hold
        dreq_hold = 1'b1;
        put_cb(32'h000, 32'h510, 32'h400, 32'hA00, 32'd16, 32'h0, 32'h0);
        ref_run(32'h000, wi);
        v1 = mem[32'hA00/4];
        start(32'h000);
        repeat (20) @(negedge clk);
        rd(6'h00, v);
        chk(v[5] == 1'b1, "R10 held bit", v, 32'h21);
        chk(mem[32'hA00/4] == v1, "R10 no write while held", mem[32'hA00/4], v1);
        dreq_hold = 1'b0;
        wait_idle();
        cmp_mem("R10 copy after hold released");

        // R11 misaligned descriptor address
        start(32'h104);
        repeat (3) @(negedge clk);
        rd(6'h00, v);
        chk(v[8] == 1'b1 && v[0] == 1'b0, "R11 misaligned error", v, 32'h110);
        wr(6'h00, 32'h8000_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule